// File: doc/BRIEF.md
# Watchdog Timer with Timed-Access Write Lock

This block watches for a stalled program. A free-running counter, advanced on every clock where the enable input is high, is brought back to zero by a restart. If no restart comes in time, the block first raises a time-out flag and, if allowed, an interrupt request. A fixed number of clocks later it issues a one-cycle reset request and latches a sticky flag that records the cause of the reset. A two-bit mode field selects one of four time-out lengths. Each step between them is a power of two.

The bits that could hurt the system if a runaway program wrote them are the reset enable and the wait-state enable. They only accept a new value inside a short window that opens after a two-byte key sequence on a key register. Other control bits are written freely. A restart is requested by the `wdt_kick` input or by writing a 1 to the restart bit of the control register. That bit is never stored, so each write restarts the counter once.

Top module: `wdt_ta_top`

## Requirements
- R1: After `rst_n` is low, all outputs are 0. The counter is 0, the control fields are 0, and the key gate is locked.
- R2: With mode field m (control bits 5:4), `wdt_tout` rises at the clock edge that completes 2^(BASE_LOG2+STEP_LOG2*m) enabled clocks after the last restart. It stays high until the next restart.
- R3: `wdt_irq` is high exactly when `wdt_tout` is high and the interrupt enable (control bit 1) is set.
- R4: Exactly RST_GAP enabled clocks after the time-out point, `wdt_rst_req` pulses high for one cycle, but only if the reset enable (control bit 2) is set. The counter then stops until the next restart.
- R5: A reset pulse sets `wdt_rst_seen`. Only `rst_n` clears it.
- R6: A restart comes from `wdt_kick`, or from a control write with bit 0 set. It zeroes the counter, clears the time-out, and cancels a pending reset. The restart bit clears itself: one write restarts once, and counting resumes on the next enabled clock.
- R7: The counter advances only on clocks where `wdt_en` is high. A restart acts regardless of `wdt_en`.
- R8: A bus write of AAh to the key address (0) arms the gate. If the next bus write is 55h to the key address, `ta_open` is high for WIN_CLKS cycles.
- R9: Reset enable (bit 2) and wait-state enable (bit 3) take a new value only from a control write (address 1) made while `ta_open` is high. At other times those two bits of the write are ignored, while the other fields still take effect.
- R10: After AAh, any write other than 55h to the key address disarms the gate. Any key write during the window closes it; AAh re-arms it. When the window runs out, the gate relocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdt_en | input | 1 | Counting enable |
| wdt_kick | input | 1 | Restart command |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Write address (0 key, 1 control) |
| bus_wdata | input | 8 | Write data |
| wdt_irq | output | 1 | Watchdog interrupt request |
| wdt_rst_req | output | 1 | One-cycle reset request |
| wdt_tout | output | 1 | Interrupt time-out reached |
| wdt_rst_seen | output | 1 | Sticky watchdog-reset cause flag |
| ta_open | output | 1 | Timed-access window open |
| rst_en_o | output | 1 | Protected reset enable |
| ws_en_o | output | 1 | Protected wait-state enable |

## Verification
The hardest state to reach is a reset request that fires with the reset enable set. That bit only changes inside an unlock window, and the counter must then run past both thresholds with no restart in between. The stimulus opens the gate with an AAh/55h pair and sets the protected bits inside the window. It then runs the counter with enable gaps to the exact threshold edges, and checks the cancel case with a kick placed one clock before the reset point. A long random phase follows, with key bytes biased toward AAh and 55h. It is checked cycle by cycle against a bench model.

// File: rtl/wdt_ta_pkg.sv
package wdt_ta_pkg;
    typedef enum logic {KEY_IDLE, KEY_ARMED} key_st_e;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    typedef struct packed {
        logic       irq_en;
        logic       rst_en;
        logic       ws_en;
        logic [1:0] mode;
    } wdt_ctrl_t;
endpackage

// File: rtl/wdt_keygate.sv
module wdt_keygate
    import wdt_ta_pkg::*;
#(
    parameter int WIN_CLKS = 12,
    parameter int ADDR_W   = 2,
    parameter int KEY_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              open_o
);
    localparam int WIN_W = $clog2(WIN_CLKS + 1);

    typedef struct packed {
        key_st_e          st;
        logic [WIN_W-1:0] win;
    } gate_t;

    gate_t g_d, g_q;
    logic  key_hit;

    assign key_hit = we && (addr == ADDR_W'(KEY_ADDR));

    always_comb begin
        g_d = g_q;
        if (g_q.win != '0) begin
            g_d.win = g_q.win - WIN_W'(1);
        end
        if (key_hit) begin
            if (wdata == KEY_FIRST) begin
                g_d.st  = KEY_ARMED;
                g_d.win = '0;
            end else if (wdata == KEY_SECOND && g_q.st == KEY_ARMED) begin
                g_d.st  = KEY_IDLE;
                g_d.win = WIN_W'(WIN_CLKS);
            end else begin
                g_d.st  = KEY_IDLE;
                g_d.win = '0;
            end
        end else if (we) begin
            g_d.st = KEY_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{st: KEY_IDLE, win: '0};
        end else begin
            g_q <= g_d;
        end
    end

    assign open_o = (g_q.win != '0);

    // R8: window only opens right after a 55h key write
    p_open_after_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(key_hit && wdata == KEY_SECOND));

    // R10: any other key write leaves the gate closed
    p_key_relock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (key_hit && wdata != KEY_SECOND) |=> !open_o);
endmodule

// File: rtl/wdt_stage_counter.sv
module wdt_stage_counter #(
    parameter int BASE_LOG2 = 17,
    parameter int STEP_LOG2 = 3,
    parameter int RST_GAP   = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       restart,
    input  logic [1:0] mode,
    input  logic       rst_en,
    output logic       tout_o,
    output logic       rst_pulse_o,
    output logic       rst_seen_o
);
    localparam int CNT_W = BASE_LOG2 + 3 * STEP_LOG2 + 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tout;
        logic             fired;
        logic             pulse;
        logic             seen;
    } stage_t;

    stage_t           s_d, s_q;
    logic [CNT_W-1:0] irq_tab [4];
    logic [CNT_W-1:0] irq_lim, rst_lim, cnt_nxt;

    for (genvar m = 0; m < 4; m++) begin : g_lim
        assign irq_tab[m] = CNT_W'(1) << (BASE_LOG2 + STEP_LOG2 * m);
    end

    assign irq_lim = irq_tab[mode];
    assign rst_lim = irq_lim + CNT_W'(RST_GAP);
    assign cnt_nxt = s_q.cnt + CNT_W'(1);

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (restart) begin
            s_d.cnt   = '0;
            s_d.tout  = 1'b0;
            s_d.fired = 1'b0;
        end else if (en && !s_q.fired) begin
            s_d.cnt = cnt_nxt;
            if (cnt_nxt >= irq_lim) begin
                s_d.tout = 1'b1;
            end
            if (cnt_nxt >= rst_lim) begin
                s_d.fired = 1'b1;
                if (rst_en) begin
                    s_d.pulse = 1'b1;
                    s_d.seen  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tout_o      = s_q.tout;
    assign rst_pulse_o = s_q.pulse;
    assign rst_seen_o  = s_q.seen;

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse_o |=> !rst_pulse_o);

    p_seen_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen_o |=> rst_seen_o);

    p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!tout_o && !rst_pulse_o && s_q.cnt == '0));

    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !restart) |=> ($stable(s_q.cnt) && !rst_pulse_o));
endmodule

// File: rtl/wdt_ta_top.sv
module wdt_ta_top
    import wdt_ta_pkg::*;
#(
    parameter int BASE_LOG2 = 17,
    parameter int STEP_LOG2 = 3,
    parameter int RST_GAP   = 512,
    parameter int WIN_CLKS  = 12,
    parameter int ADDR_W    = 2,
    parameter int KEY_ADDR  = 0,
    parameter int CTRL_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdt_en,
    input  logic              wdt_kick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              wdt_irq,
    output logic              wdt_rst_req,
    output logic              wdt_tout,
    output logic              wdt_rst_seen,
    output logic              ta_open,
    output logic              rst_en_o,
    output logic              ws_en_o
);
    wdt_ctrl_t ctrl_d, ctrl_q;
    logic      ctrl_hit, restart;

    assign ctrl_hit = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));
    assign restart  = wdt_kick || (ctrl_hit && bus_wdata[0]);

    wdt_keygate #(
        .WIN_CLKS (WIN_CLKS),
        .ADDR_W   (ADDR_W),
        .KEY_ADDR (KEY_ADDR)
    ) i_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .open_o (ta_open)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_hit) begin
            ctrl_d.irq_en = bus_wdata[1];
            ctrl_d.mode   = bus_wdata[5:4];
            if (ta_open) begin
                ctrl_d.rst_en = bus_wdata[2];
                ctrl_d.ws_en  = bus_wdata[3];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    wdt_stage_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2),
        .RST_GAP   (RST_GAP)
    ) i_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (wdt_en),
        .restart     (restart),
        .mode        (ctrl_q.mode),
        .rst_en      (ctrl_q.rst_en),
        .tout_o      (wdt_tout),
        .rst_pulse_o (wdt_rst_req),
        .rst_seen_o  (wdt_rst_seen)
    );

    assign wdt_irq  = wdt_tout && ctrl_q.irq_en;
    assign rst_en_o = ctrl_q.rst_en;
    assign ws_en_o  = ctrl_q.ws_en;

    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_open |=> ($stable(ctrl_q.rst_en) && $stable(ctrl_q.ws_en)));

    p_pulse_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |-> $past(ctrl_q.rst_en));
endmodule

// File: tb/test_wdt_ta_top.sv
module test_wdt_ta_top;
    localparam int CLK_P = 10;
    localparam int BASE  = 6;
    localparam int STEP  = 1;
    localparam int GAP   = 32;
    localparam int WIN   = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_en = 1'b0, wdt_kick = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       wdt_irq, wdt_rst_req, wdt_tout, wdt_rst_seen, ta_open, rst_en_o, ws_en_o;

    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;

    // bench model
    int  m_cnt, m_win, m_mode;
    bit  m_tout, m_fired, m_pulse, m_seen, m_armed, m_irqen, m_rsten, m_wsen;

    wdt_ta_top #(
        .BASE_LOG2 (BASE), .STEP_LOG2 (STEP), .RST_GAP (GAP), .WIN_CLKS (WIN),
        .ADDR_W (2), .KEY_ADDR (0), .CTRL_ADDR (1)
    ) i_wdt_ta_top (
        .clk (clk), .rst_n (rst_n), .wdt_en (wdt_en), .wdt_kick (wdt_kick),
        .bus_we (bus_we), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .wdt_irq (wdt_irq), .wdt_rst_req (wdt_rst_req), .wdt_tout (wdt_tout),
        .wdt_rst_seen (wdt_rst_seen), .ta_open (ta_open),
        .rst_en_o (rst_en_o), .ws_en_o (ws_en_o)
    );

    always #(CLK_P / 2) clk = ~clk;

    function automatic int tout_len(int mode);
        return 1 << (BASE + STEP * mode);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit restart, open_now;
        int nwin;
        bit narmed;
        if (!rst_n) begin
            m_cnt = 0; m_win = 0; m_mode = 0; m_tout = 0; m_fired = 0; m_pulse = 0;
            m_seen = 0; m_armed = 0; m_irqen = 0; m_rsten = 0; m_wsen = 0;
            return;
        end
        restart  = wdt_kick || (bus_we && bus_addr == 2'd1 && bus_wdata[0]);
        open_now = (m_win > 0);
        // staging counter, using control values held before this edge
        m_pulse = 0;
        if (restart) begin
            m_cnt = 0; m_tout = 0; m_fired = 0;
        end else if (wdt_en && !m_fired) begin
            m_cnt++;
            if (m_cnt >= tout_len(m_mode)) m_tout = 1;
            if (m_cnt >= tout_len(m_mode) + GAP) begin
                m_fired = 1;
                if (m_rsten) begin m_pulse = 1; m_seen = 1; end
            end
        end
        // key gate
        nwin = open_now ? m_win - 1 : 0;
        narmed = m_armed;
        if (bus_we) begin
            if (bus_addr == 2'd0) begin
                if (bus_wdata == 8'hAA) begin narmed = 1; nwin = 0; end
                else if (bus_wdata == 8'h55 && m_armed) begin narmed = 0; nwin = WIN; end
                else begin narmed = 0; nwin = 0; end
            end else begin
                narmed = 0;
            end
        end
        // control register
        if (bus_we && bus_addr == 2'd1) begin
            m_irqen = bus_wdata[1];
            m_mode  = int'(bus_wdata[5:4]);
            if (open_now) begin m_rsten = bus_wdata[2]; m_wsen = bus_wdata[3]; end
        end
        m_win = nwin; m_armed = narmed;
    endtask

    task automatic compare();
        chk("R2 tout", wdt_tout, m_tout);
        chk("R3 irq", wdt_irq, m_tout && m_irqen);
        chk("R4 rst_req", wdt_rst_req, m_pulse);
        chk("R5 rst_seen", wdt_rst_seen, m_seen);
        chk("R8 ta_open", ta_open, m_win > 0);
        chk("R9 rst_en", rst_en_o, m_rsten);
        chk("R9 ws_en", ws_en_o, m_wsen);
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        bus_we = 1'b0;
        wdt_kick = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
    endtask

    task automatic run_en(int n);
        for (int k = 0; k < n; k++) begin
            wdt_en = 1'b1;
            step();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit saw;
        void'($urandom(32'd4242));
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", wdt_irq, 0);       chk("R1 rst_req", wdt_rst_req, 0);
        chk("R1 tout", wdt_tout, 0);     chk("R1 seen", wdt_rst_seen, 0);
        chk("R1 open", ta_open, 0);      chk("R1 rst_en", rst_en_o, 0);
        chk("R1 ws_en", ws_en_o, 0);

        // R9 locked write ignored for protected bits
        wr(2'd1, 8'h0E);
        chk("R9 locked rst_en", rst_en_o, 0);
        chk("R9 locked ws_en", ws_en_o, 0);

        // R8 unlock then protected write
        wr(2'd0, 8'hAA);
        wr(2'd0, 8'h55);
        chk("R8 open after key", ta_open, 1);
        wdt_en = 1'b1;
        wr(2'd1, 8'h0F);
        chk("R9 unlocked rst_en", rst_en_o, 1);
        chk("R9 unlocked ws_en", ws_en_o, 1);

        // R2/R6/R7 exact time-out with enable gaps, mode 0
        for (int k = 1; k <= tout_len(0) - 1; k++) begin
            wdt_en = 1'b1; step();
            if (k % 3 == 0) begin wdt_en = 1'b0; step(); end
        end
        chk("R2 R7 tout before limit", wdt_tout, 0);
        run_en(1);
        chk("R2 R6 tout at limit", wdt_tout, 1);
        chk("R3 irq at limit", wdt_irq, 1);
        run_en(GAP - 1);
        chk("R4 no reset before gap", wdt_rst_req, 0);
        run_en(1);
        chk("R4 reset pulse", wdt_rst_req, 1);
        chk("R5 seen set", wdt_rst_seen, 1);
        run_en(1);
        chk("R4 pulse one cycle", wdt_rst_req, 0);
        wdt_kick = 1'b1; step();
        chk("R6 kick clears tout", wdt_tout, 0);
        chk("R5 seen sticky", wdt_rst_seen, 1);

        // R10 abort by intervening write
        wr(2'd0, 8'hAA);
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h55);
        chk("R10 aborted sequence", ta_open, 0);
        // R10 window expiry
        wr(2'd0, 8'hAA);
        wr(2'd0, 8'h55);
        repeat (WIN - 1) step();
        chk("R10 open at last cycle", ta_open, 1);
        step();
        chk("R10 expired", ta_open, 0);

        // R6 restart one clock before the reset point cancels it
        wr(2'd1, 8'h03);
        run_en(tout_len(0) + GAP - 1);
        wdt_kick = 1'b1; step();
        saw = 0;
        for (int k = 0; k < 90; k++) begin
            wdt_en = 1'b1; step();
            if (wdt_rst_req) saw = 1;
        end
        chk("R6 pre-empted reset", saw, 0);

        // R2 mode 2 length
        wr(2'd1, 8'h23);
        run_en(tout_len(2) - 1);
        chk("R2 mode2 before", wdt_tout, 0);
        run_en(1);
        chk("R2 mode2 at limit", wdt_tout, 1);

        // random phase
        for (int c = 0; c < 20000; c++) begin
            wdt_en   = ($urandom % 8) != 0;
            wdt_kick = ($urandom % 500) == 0;
            if ($urandom % 16 == 0) begin
                bus_we   = 1'b1;
                bus_addr = 2'($urandom % 2);
                if (bus_addr == 2'd0) begin
                    case ($urandom % 5)
                        0, 1:    bus_wdata = 8'hAA;
                        2, 3:    bus_wdata = 8'h55;
                        default: bus_wdata = 8'($urandom);
                    endcase
                end else begin
                    bus_wdata = 8'($urandom);
                    if ($urandom % 8 != 0) bus_wdata[0] = 1'b0;
                end
            end
            step();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule